// File: doc/BRIEF.md
# Hub Downstream Port Power Controller

This block switches power for the downstream ports of a USB hub and watches each port for over-current. The hub command logic sends single-cycle power-on and power-off requests for each port. The block drives one active-low enable per port to the external power switches. Over-current inputs from those switches are active low. Each one is debounced by a consecutive-sample filter before it can act on a port.

A static mode strap selects how ports are grouped. In per-port mode, every enable, fault input, change bit and clear strobe belongs to its own port. In ganged mode, the ports behave as a single group:

- They power on and off together.
- A filtered fault on any input shuts every port down.
- A single shared change bit is reported on every port position.

After a shutdown caused by over-current, a port stays off until it receives a fresh power-on request while no filtered fault is present.

Top module: `ppc_hub_power`

## Requirements
- R1: While reset is low and right after it rises, every `pwr_en_n` bit is 1 (unpowered), and `oc_stat` and `oc_chg` are all 0.
- R2: In per-port mode (`gang_strap`=0), a one-cycle `pwr_on_req[i]` drives `pwr_en_n[i]` to 0 on the next clock edge, and a one-cycle `pwr_off_req[i]` drives it back to 1. No other port changes.
- R3: An `oc_n[i]` low pulse that lasts fewer than FILT_LEN (default 16) consecutive clock samples is ignored. `oc_stat`, `oc_chg` and `pwr_en_n` stay unchanged.
- R4: Once `oc_n[i]` has been low for FILT_LEN consecutive samples, `oc_stat[i]` reads 1, and the port's `pwr_en_n[i]` goes to 1 one edge later. `oc_stat[i]` returns to 0 on the first sample at which `oc_n[i]` is high.
- R5: In per-port mode, a filtered fault on one port leaves the power state, `oc_stat` and `oc_chg` bits of every other port unchanged.
- R6: In ganged mode, a filtered fault on any input sets all `oc_stat` bits and drives all `pwr_en_n` bits to 1.
- R7: In ganged mode, a power-on request on any port powers all ports, and a power-off request on any port unpowers all ports.
- R8: A filtered fault that begins sets `oc_chg` for that port, or for all ports in ganged mode. The bit stays set after the fault clears and drops only on an `oc_clr` strobe for that port (in ganged mode, any `oc_clr` bit).
- R9: A power-on request is ignored while the filtered fault for that port is active. After the fault clears, a new request powers the port.
- R10: When power-on and power-off requests reach a port in the same cycle, the port ends up unpowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| gang_strap | input | 1 | 1 = ganged mode, 0 = per-port mode; static |
| pwr_on_req | input | NPORTS | Per-port power-on request strobes |
| pwr_off_req | input | NPORTS | Per-port power-off request strobes |
| oc_n | input | NPORTS | Active-low over-current inputs, unfiltered |
| oc_clr | input | NPORTS | Strobes that clear the change bits |
| pwr_en_n | output | NPORTS | Active-low power enables (0 = powered) |
| oc_stat | output | NPORTS | Filtered over-current status per port |
| oc_chg | output | NPORTS | Sticky over-current change bits |

## Verification
The hardest case to reach is the exact filter boundary. A pulse one sample short of the filter length must leave no trace, while a pulse of exactly the filter length must set the change bit even though the input has already been released. The bench drives `oc_n` on falling edges, so it controls precisely how many rising edges sample the low level. It then checks that the shorter pulse leaves power and status untouched, and that the exact-length pulse latches the change bit. It also sends a power-on request while the filtered fault is held, to confirm that the request is refused.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
   // width of a saturating counter that must reach the value lim
   function automatic int unsigned cnt_width(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction
endpackage

// File: rtl/ppc_oc_filter.sv
module ppc_oc_filter #(
   parameter int unsigned FILT_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_n,
   output logic flt
);
   localparam int unsigned CW = ppc_pkg::cnt_width(FILT_LEN);
   localparam logic [CW-1:0] LIM = CW'(FILT_LEN);

   logic [CW-1:0] run_q;

   // count consecutive low samples, saturating at the limit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_q <= '0;
      else if (oc_n)         run_q <= '0;
      else if (run_q != LIM) run_q <= run_q + 1'b1;
   end

   assign flt = (run_q == LIM);

   // R3: a filtered fault implies the input was low at the last sample
   a_r3_flt_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      flt |-> $past(!oc_n));
endmodule

// File: rtl/ppc_group_merge.sv
module ppc_group_merge #(
   parameter int unsigned NPORTS = 4
) (
   input  logic              gang,
   input  logic [NPORTS-1:0] on_req,
   input  logic [NPORTS-1:0] off_req,
   input  logic [NPORTS-1:0] flt,
   input  logic [NPORTS-1:0] clr,
   output logic [NPORTS-1:0] on_eff,
   output logic [NPORTS-1:0] off_eff,
   output logic [NPORTS-1:0] flt_eff,
   output logic [NPORTS-1:0] clr_eff
);
   logic any_on, any_off, any_flt, any_clr;

   assign any_on  = |on_req;
   assign any_off = |off_req;
   assign any_flt = |flt;
   assign any_clr = |clr;

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      assign on_eff[i]  = gang ? any_on  : on_req[i];
      assign off_eff[i] = gang ? any_off : off_req[i];
      assign flt_eff[i] = gang ? any_flt : flt[i];
      assign clr_eff[i] = gang ? any_clr : clr[i];
   end
endmodule

// File: rtl/ppc_port_ctl.sv
module ppc_port_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic on_req,
   input  logic off_req,
   input  logic oc_act,
   input  logic clr,
   output logic pwr_on,
   output logic chg
);
   logic oc_prev_q;

   // fault beats off, off beats on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pwr_on <= 1'b0;
      else if (oc_act)  pwr_on <= 1'b0;
      else if (off_req) pwr_on <= 1'b0;
      else if (on_req)  pwr_on <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_prev_q <= 1'b0;
         chg       <= 1'b0;
      end else begin
         oc_prev_q <= oc_act;
         if (oc_act && !oc_prev_q) chg <= 1'b1;
         else if (clr)             chg <= 1'b0;
      end
   end

   a_r4_fault_unpowers: assert property (@(posedge clk) disable iff (!rst_n)
      oc_act |=> !pwr_on);
   a_r8_chg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      chg && !clr |=> chg);
   a_r10_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
      on_req && off_req |=> !pwr_on);
   a_r2_on_takes: assert property (@(posedge clk) disable iff (!rst_n)
      on_req && !off_req && !oc_act |=> pwr_on);
endmodule

// File: rtl/ppc_hub_power.sv
module ppc_hub_power #(
   parameter int unsigned NPORTS   = 4,
   parameter int unsigned FILT_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gang_strap,
   input  logic [NPORTS-1:0] pwr_on_req,
   input  logic [NPORTS-1:0] pwr_off_req,
   input  logic [NPORTS-1:0] oc_n,
   input  logic [NPORTS-1:0] oc_clr,
   output logic [NPORTS-1:0] pwr_en_n,
   output logic [NPORTS-1:0] oc_stat,
   output logic [NPORTS-1:0] oc_chg
);
   if (NPORTS < 1) begin : g_bad_ports
      $error("ppc_hub_power: NPORTS must be at least 1");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("ppc_hub_power: FILT_LEN must be at least 2");
   end

   logic [NPORTS-1:0] flt_raw, on_eff, off_eff, flt_eff, clr_eff, pwr_on;

   for (genvar i = 0; i < NPORTS; i++) begin : g_filt
      ppc_oc_filter #(.FILT_LEN(FILT_LEN)) u_filt (
         .clk (clk), .rst_n (rst_n), .oc_n (oc_n[i]), .flt (flt_raw[i]));
   end

   ppc_group_merge #(.NPORTS(NPORTS)) u_merge (
      .gang    (gang_strap),
      .on_req  (pwr_on_req),
      .off_req (pwr_off_req),
      .flt     (flt_raw),
      .clr     (oc_clr),
      .on_eff  (on_eff),
      .off_eff (off_eff),
      .flt_eff (flt_eff),
      .clr_eff (clr_eff));

   for (genvar i = 0; i < NPORTS; i++) begin : g_ctl
      ppc_port_ctl u_ctl (
         .clk     (clk),
         .rst_n   (rst_n),
         .on_req  (on_eff[i]),
         .off_req (off_eff[i]),
         .oc_act  (flt_eff[i]),
         .clr     (clr_eff[i]),
         .pwr_on  (pwr_on[i]),
         .chg     (oc_chg[i]));
   end

   assign pwr_en_n = ~pwr_on;
   assign oc_stat  = flt_eff;

   // R6: in ganged mode all enables move as one group
   a_r6_gang_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      gang_strap |-> (pwr_en_n == '0 || pwr_en_n == '1));
   // R6: in ganged mode all status bits agree
   a_r6_gang_stat: assert property (@(posedge clk) disable iff (!rst_n)
      gang_strap |-> (oc_stat == '0 || oc_stat == '1));
   // R5: per-port mode, a port without its own fault keeps its change bit
   a_r5_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
      !gang_strap && oc_stat == '0 && oc_clr == '0 |=> $stable(oc_chg));
endmodule

// File: tb/ppc_hub_power_tb.sv
module ppc_hub_power_tb_top;
   localparam int N = 4;
   localparam int FL = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gang_strap = 1'b0;
   logic [N-1:0] pwr_on_req = '0, pwr_off_req = '0, oc_n = '1, oc_clr = '0;
   logic [N-1:0] pwr_en_n, oc_stat, oc_chg;
   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   ppc_hub_power #(.NPORTS(N), .FILT_LEN(FL)) dut_i (
      .clk (clk), .rst_n (rst_n), .gang_strap (gang_strap),
      .pwr_on_req (pwr_on_req), .pwr_off_req (pwr_off_req),
      .oc_n (oc_n), .oc_clr (oc_clr),
      .pwr_en_n (pwr_en_n), .oc_stat (oc_stat), .oc_chg (oc_chg));

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic g);
      @(negedge clk);
      rst_n = 1'b0; gang_strap = g;
      pwr_on_req = '0; pwr_off_req = '0; oc_n = '1; oc_clr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic req(input logic [N-1:0] on_m, input logic [N-1:0] off_m);
      pwr_on_req = on_m; pwr_off_req = off_m;
      @(negedge clk);
      pwr_on_req = '0; pwr_off_req = '0;
   endtask

   task automatic clr(input logic [N-1:0] m);
      oc_clr = m;
      @(negedge clk);
      oc_clr = '0;
   endtask

   // hold oc_n[p] low for exactly n sampling edges
   task automatic oc_pulse(input int p, input int n);
      oc_n[p] = 1'b0;
      repeat (n) @(negedge clk);
      oc_n[p] = 1'b1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 en during reset", pwr_en_n, '1);
      do_reset(1'b0);
      chk("R1 en after reset", pwr_en_n, '1);
      chk("R1 stat after reset", oc_stat, '0);
      chk("R1 chg after reset", oc_chg, '0);
   endtask

   task automatic t_perport;
      do_reset(1'b0);
      req(4'b0010, '0);
      chk("R2 on port1", pwr_en_n, 4'b1101);
      req(4'b1000, '0);
      chk("R2 on port3", pwr_en_n, 4'b0101);
      req('0, 4'b0010);
      chk("R2 off port1", pwr_en_n, 4'b0111);
      req(4'b0001, 4'b0001);
      chk("R10 on+off same cycle", pwr_en_n, 4'b0111);
   endtask

   task automatic t_glitch;
      req(4'b0100, '0);
      chk("R2 on port2", pwr_en_n, 4'b0011);
      oc_pulse(2, FL - 1);
      repeat (3) @(negedge clk);
      chk("R3 short pulse chg", oc_chg, '0);
      chk("R3 short pulse stat", oc_stat, '0);
      chk("R3 short pulse power", pwr_en_n, 4'b0011);
   endtask

   task automatic t_fault_perport;
      oc_n[2] = 1'b0;
      repeat (FL) @(negedge clk);
      chk("R4 stat at limit", oc_stat, 4'b0100);
      @(negedge clk);
      chk("R4/R5 port2 off only", pwr_en_n, 4'b0111);
      chk("R8/R5 chg port2 only", oc_chg, 4'b0100);
      req(4'b0100, '0);
      chk("R9 on ignored in fault", pwr_en_n, 4'b0111);
      oc_n[2] = 1'b1;
      @(negedge clk);
      chk("R4 stat released", oc_stat, '0);
      repeat (2) @(negedge clk);
      chk("R8 chg sticky", oc_chg, 4'b0100);
      clr(4'b0001);
      chk("R8 other clr no effect", oc_chg, 4'b0100);
      clr(4'b0100);
      chk("R8 chg cleared", oc_chg, '0);
      req(4'b0100, '0);
      chk("R9 on after fault", pwr_en_n, 4'b0011);
      // exact-length pulse still latches the change bit
      oc_pulse(0, FL);
      repeat (2) @(negedge clk);
      chk("R3/R8 exact-length pulse", oc_chg, 4'b0001);
      chk("R5 others still on", pwr_en_n, 4'b0011);
   endtask

   task automatic t_gang;
      do_reset(1'b1);
      req(4'b0001, '0);
      chk("R7 gang on", pwr_en_n, 4'b0000);
      req('0, 4'b1000);
      chk("R7 gang off", pwr_en_n, 4'b1111);
      req(4'b0100, '0);
      chk("R7 gang on again", pwr_en_n, 4'b0000);
      oc_n[1] = 1'b0;
      repeat (FL + 1) @(negedge clk);
      chk("R6 gang stat", oc_stat, 4'b1111);
      chk("R6 gang power off", pwr_en_n, 4'b1111);
      chk("R8 gang chg", oc_chg, 4'b1111);
      oc_n[1] = 1'b1;
      repeat (2) @(negedge clk);
      clr(4'b1000);
      chk("R8 gang clear", oc_chg, 4'b0000);
      req(4'b0010, '0);
      chk("R9 gang repower", pwr_en_n, 4'b0000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_perport();
      t_glitch();
      t_fault_perport();
      t_gang();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule